// File: doc/BRIEF.md
# Relocatable I/O Window Decoder

This block is the configuration side of a power-management PCI function that owns two I/O windows: a 128-byte power-management window and a 16-byte SMBus window. Software places each window by writing a base register and turns it on through an enable bit that sits in a different configuration byte. The block keeps only the address bits that a window of that size can use. It forces bit 0 of each base register to one, so a read always shows the masked value. It also keeps only the meaningful bits of the SMBus enable byte.

On the host I/O side the block decodes every address continuously. For each window it raises a hit flag and gives the offset inside that window. The power-management window accepts only single-byte accesses. When the two windows overlap, the power-management window owns the shared addresses. A dword-wide configuration port with byte enables stands in for the PCI configuration bus, so a write can touch one to four bytes of a dword.

Top module: `iowin_cfg_decoder`

## Requirements
- R1: After reset, dwords 0x48 and 0x90 read 0x00000001, dwords 0x40 and 0xD0 read 0x00000000, and no hit flag is raised.
- R2: The power-management base is the dword at byte offset 0x48. After any write to any of its bytes it holds write-data bits [15:7] and reads back with bits [6:1] and [31:16] zero and bit 0 one.
- R3: The SMBus base is the dword at byte offset 0x90. After any write to any of its bytes it holds write-data bits [15:4] and reads back with bits [3:1] and [31:16] zero and bit 0 one.
- R4: cfg_rdata shows, in the same cycle, the dword at byte offset 4*cfg_dw_addr, with byte n in bits [8n+7:8n]. A write with cfg_wr high takes effect at the next rising clock edge.
- R5: Byte 0x41 (dword 0x40, lane 1) stores all 8 written bits, and its bit 7 enables the power-management window.
- R6: Byte 0xD2 (dword 0xD0, lane 2) keeps only the low 4 written bits, and its bit 0 enables the SMBus window.
- R7: A write changes only the bytes whose cfg_be bit is set (cfg_be[n] selects byte n of the dword).
- R8: Every other configuration byte reads zero, and writes to it change nothing.
- R9: pm_hit is high exactly when the power-management window is enabled, io_single is high and io_addr[15:7] equals the stored base bits.
- R10: smb_hit is high exactly when the SMBus window is enabled, io_addr[15:4] equals the stored base bits, and the address is not inside the enabled power-management window.
- R11: pm_off equals io_addr[6:0] while pm_hit is high, and smb_off equals io_addr[3:0] while smb_hit is high. Both are zero otherwise.
- R12: An access with io_single low inside the enabled power-management window raises neither hit flag.
- R13: If both enabled windows cover the address, only the power-management window can hit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_dw_addr | input | 6 | Configuration dword index (byte offset / 4), used for read and write |
| cfg_be | input | 4 | Byte enables of the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for cfg_dw_addr |
| io_addr | input | 16 | Host I/O address |
| io_single | input | 1 | High for a single-byte I/O access |
| pm_hit | output | 1 | Address falls in the power-management window |
| pm_off | output | 7 | Offset inside the power-management window |
| smb_hit | output | 1 | Address falls in the SMBus window |
| smb_off | output | 4 | Offset inside the SMBus window |

## Verification
A configuration write is due at the first rising edge after it is driven. From that edge onward, both the readback and the decode use the new value. The read port and the decode outputs are combinational, so they are due within the same cycle as the address that produces them. The bench drives each stimulus on the falling edge and compares all outputs against its reference model one nanosecond later. It applies the write to the model only after the following rising edge, so every compare sees exactly the state that the design holds in that cycle.

// File: rtl/iowin_pkg.sv
package iowin_pkg;
  localparam int CFG_DW_AW = 6;

  // dword indexes (byte offset / 4) and byte lanes of the decoded registers
  localparam logic [CFG_DW_AW-1:0] PM_BASE_DW  = 6'h12;
  localparam logic [CFG_DW_AW-1:0] PM_CTL_DW   = 6'h10;
  localparam int                   PM_CTL_LANE = 1;
  localparam int                   PM_EN_BIT   = 7;
  localparam logic [7:0]           PM_CTL_KEEP = 8'hFF;

  localparam logic [CFG_DW_AW-1:0] SMB_BASE_DW  = 6'h24;
  localparam logic [CFG_DW_AW-1:0] SMB_CTL_DW   = 6'h34;
  localparam int                   SMB_CTL_LANE = 2;
  localparam int                   SMB_EN_BIT   = 0;
  localparam logic [7:0]           SMB_CTL_KEEP = 8'h0F;

  typedef struct packed {
    logic                 en;
    logic [CFG_DW_AW-1:0] dw;
    logic [3:0]           be;
    logic [31:0]          data;
  } cfg_wr_t;
endpackage

// File: rtl/iowin_base_reg.sv
module iowin_base_reg
  import iowin_pkg::*;
#(
  parameter int                   ADDR_W   = 16,
  parameter int                   WIN_LOG2 = 7,
  parameter logic [CFG_DW_AW-1:0] DW_SEL   = '0
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  cfg_wr_t                    wr,
  input  logic [CFG_DW_AW-1:0]       rd_dw,
  output logic [ADDR_W-1:WIN_LOG2]   base_q,
  output logic [31:0]                rd_data
);
  logic [31:0]              cur_img;
  logic [31:0]              new_img;
  logic [ADDR_W-1:WIN_LOG2] base_d;
  logic                     base_ce;
  logic                     unused_img;

  // image of the register as software sees it, then merged with written lanes
  always_comb begin
    cur_img                    = '0;
    cur_img[ADDR_W-1:WIN_LOG2] = base_q;
    cur_img[0]                 = 1'b1;
    new_img                    = cur_img;
    for (int l = 0; l < 4; l++) begin
      if (wr.be[l]) new_img[8*l +: 8] = wr.data[8*l +: 8];
    end
    base_ce = wr.en && (wr.dw == DW_SEL) && (|wr.be);
    base_d  = new_img[ADDR_W-1:WIN_LOG2];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       base_q <= '0;
    else if (base_ce) base_q <= base_d;
  end

  assign rd_data    = (rd_dw == DW_SEL) ? cur_img : '0;
  assign unused_img = ^new_img;
endmodule

// File: rtl/iowin_ctl_reg.sv
module iowin_ctl_reg
  import iowin_pkg::*;
#(
  parameter logic [CFG_DW_AW-1:0] DW_SEL = '0,
  parameter int                   LANE   = 0,
  parameter logic [7:0]           KEEP   = 8'hFF
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  cfg_wr_t              wr,
  input  logic [CFG_DW_AW-1:0] rd_dw,
  output logic [7:0]           ctl_q,
  output logic [31:0]          rd_data
);
  logic [7:0] ctl_d;
  logic       ctl_ce;
  logic       unused_data;

  always_comb begin
    ctl_ce = wr.en && (wr.dw == DW_SEL) && wr.be[LANE];
    ctl_d  = wr.data[8*LANE +: 8] & KEEP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctl_q <= '0;
    else if (ctl_ce) ctl_q <= ctl_d;
  end

  always_comb begin
    rd_data = '0;
    if (rd_dw == DW_SEL) rd_data[8*LANE +: 8] = ctl_q;
  end

  assign unused_data = ^wr.data;
endmodule

// File: rtl/iowin_match.sv
module iowin_match #(
  parameter int ADDR_W   = 16,
  parameter int WIN_LOG2 = 7
) (
  input  logic [ADDR_W-1:0]        io_addr,
  input  logic [ADDR_W-1:WIN_LOG2] base,
  input  logic                     en,
  output logic                     match,
  output logic [WIN_LOG2-1:0]      offset
);
  assign match  = en && (io_addr[ADDR_W-1:WIN_LOG2] == base);
  assign offset = io_addr[WIN_LOG2-1:0];
endmodule

// File: rtl/iowin_cfg_decoder.sv
module iowin_cfg_decoder
  import iowin_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int PM_LOG2  = 7,
  parameter int SMB_LOG2 = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_wr,
  input  logic [CFG_DW_AW-1:0] cfg_dw_addr,
  input  logic [3:0]           cfg_be,
  input  logic [31:0]          cfg_wdata,
  output logic [31:0]          cfg_rdata,
  input  logic [ADDR_W-1:0]    io_addr,
  input  logic                 io_single,
  output logic                 pm_hit,
  output logic [PM_LOG2-1:0]   pm_off,
  output logic                 smb_hit,
  output logic [SMB_LOG2-1:0]  smb_off
);
  cfg_wr_t                   wr_bus;
  logic [ADDR_W-1:PM_LOG2]   pm_base_q;
  logic [ADDR_W-1:SMB_LOG2]  smb_base_q;
  logic [7:0]                pm_ctl_q;
  logic [7:0]                smb_ctl_q;
  logic [31:0]               pm_base_rd, smb_base_rd, pm_ctl_rd, smb_ctl_rd;
  logic                      pm_match, smb_match;
  logic [PM_LOG2-1:0]        pm_raw_off;
  logic [SMB_LOG2-1:0]       smb_raw_off;
  logic                      unused_ctl;

  assign wr_bus = {cfg_wr, cfg_dw_addr, cfg_be, cfg_wdata};

  iowin_base_reg #(.ADDR_W(ADDR_W), .WIN_LOG2(PM_LOG2), .DW_SEL(PM_BASE_DW)) u_pm_base (
    .clk(clk), .rst_n(rst_n), .wr(wr_bus), .rd_dw(cfg_dw_addr),
    .base_q(pm_base_q), .rd_data(pm_base_rd));

  iowin_base_reg #(.ADDR_W(ADDR_W), .WIN_LOG2(SMB_LOG2), .DW_SEL(SMB_BASE_DW)) u_smb_base (
    .clk(clk), .rst_n(rst_n), .wr(wr_bus), .rd_dw(cfg_dw_addr),
    .base_q(smb_base_q), .rd_data(smb_base_rd));

  iowin_ctl_reg #(.DW_SEL(PM_CTL_DW), .LANE(PM_CTL_LANE), .KEEP(PM_CTL_KEEP)) u_pm_ctl (
    .clk(clk), .rst_n(rst_n), .wr(wr_bus), .rd_dw(cfg_dw_addr),
    .ctl_q(pm_ctl_q), .rd_data(pm_ctl_rd));

  iowin_ctl_reg #(.DW_SEL(SMB_CTL_DW), .LANE(SMB_CTL_LANE), .KEEP(SMB_CTL_KEEP)) u_smb_ctl (
    .clk(clk), .rst_n(rst_n), .wr(wr_bus), .rd_dw(cfg_dw_addr),
    .ctl_q(smb_ctl_q), .rd_data(smb_ctl_rd));

  assign cfg_rdata = pm_base_rd | smb_base_rd | pm_ctl_rd | smb_ctl_rd;

  iowin_match #(.ADDR_W(ADDR_W), .WIN_LOG2(PM_LOG2)) u_pm_match (
    .io_addr(io_addr), .base(pm_base_q), .en(pm_ctl_q[PM_EN_BIT]),
    .match(pm_match), .offset(pm_raw_off));

  iowin_match #(.ADDR_W(ADDR_W), .WIN_LOG2(SMB_LOG2)) u_smb_match (
    .io_addr(io_addr), .base(smb_base_q), .en(smb_ctl_q[SMB_EN_BIT]),
    .match(smb_match), .offset(smb_raw_off));

  // power-management window owns any address it matches, whatever the width
  always_comb begin
    pm_hit  = pm_match && io_single;
    smb_hit = smb_match && !pm_match;
    pm_off  = pm_hit  ? pm_raw_off  : '0;
    smb_off = smb_hit ? smb_raw_off : '0;
  end

  assign unused_ctl = ^{pm_ctl_q, smb_ctl_q};
endmodule

// File: rtl/iowin_cfg_checker.sv
module iowin_cfg_checker
  import iowin_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int PM_LOG2  = 7,
  parameter int SMB_LOG2 = 4
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     cfg_wr,
  input logic [CFG_DW_AW-1:0]     cfg_dw_addr,
  input logic [31:0]              cfg_rdata,
  input logic [ADDR_W-1:0]        io_addr,
  input logic                     io_single,
  input logic                     pm_hit,
  input logic [PM_LOG2-1:0]       pm_off,
  input logic                     smb_hit,
  input logic [SMB_LOG2-1:0]      smb_off,
  input logic [ADDR_W-1:PM_LOG2]  pm_base_q,
  input logic [ADDR_W-1:SMB_LOG2] smb_base_q,
  input logic [7:0]               pm_ctl_q,
  input logic [7:0]               smb_ctl_q
);
  // R2
  pm_base_fmt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_dw_addr == PM_BASE_DW) |->
      (cfg_rdata[0] && cfg_rdata[PM_LOG2-1:1] == '0 && cfg_rdata[31:ADDR_W] == '0));

  // R3
  smb_base_fmt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_dw_addr == SMB_BASE_DW) |->
      (cfg_rdata[0] && cfg_rdata[SMB_LOG2-1:1] == '0 && cfg_rdata[31:ADDR_W] == '0));

  // R6
  smb_ctl_nibble_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_dw_addr == SMB_CTL_DW) |-> (cfg_rdata[8*SMB_CTL_LANE+4 +: 4] == 4'h0));

  // R8
  no_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr |=> ($stable(pm_base_q) && $stable(smb_base_q) &&
                 $stable(pm_ctl_q) && $stable(smb_ctl_q)));

  // R9
  pm_hit_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pm_hit |-> (pm_ctl_q[PM_EN_BIT] && io_addr[ADDR_W-1:PM_LOG2] == pm_base_q));

  // R10
  smb_hit_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smb_hit |-> (smb_ctl_q[SMB_EN_BIT] && io_addr[ADDR_W-1:SMB_LOG2] == smb_base_q));

  // R11
  idle_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((!pm_hit |-> pm_off == '0) and (!smb_hit |-> smb_off == '0)));

  // R12
  wide_no_pm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !io_single |-> !pm_hit);

  // R13
  single_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pm_hit && smb_hit));
endmodule

bind iowin_cfg_decoder iowin_cfg_checker #(
  .ADDR_W(ADDR_W), .PM_LOG2(PM_LOG2), .SMB_LOG2(SMB_LOG2)
) i_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_dw_addr(cfg_dw_addr),
  .cfg_rdata(cfg_rdata), .io_addr(io_addr), .io_single(io_single),
  .pm_hit(pm_hit), .pm_off(pm_off), .smb_hit(smb_hit), .smb_off(smb_off),
  .pm_base_q(pm_base_q), .smb_base_q(smb_base_q),
  .pm_ctl_q(pm_ctl_q), .smb_ctl_q(smb_ctl_q)
);

// File: tb/test_iowin_cfg_decoder.sv
module test_iowin_cfg_decoder;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_wr;
  logic [5:0]  cfg_dw_addr;
  logic [3:0]  cfg_be;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata;
  logic [15:0] io_addr;
  logic        io_single;
  logic        pm_hit, smb_hit;
  logic [6:0]  pm_off;
  logic [3:0]  smb_off;

  int checks = 0;
  int errors = 0;
  logic [7:0] mdl [256];

  always #2 clk = ~clk;

  iowin_cfg_decoder i_iowin_cfg_decoder (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_dw_addr(cfg_dw_addr),
    .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .io_addr(io_addr), .io_single(io_single), .pm_hit(pm_hit), .pm_off(pm_off),
    .smb_hit(smb_hit), .smb_off(smb_off));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic bit kept_byte(input int a);
    return (a == 8'h41) || (a >= 8'h48 && a <= 8'h4B) ||
           (a >= 8'h90 && a <= 8'h93) || (a == 8'hD2);
  endfunction

  task automatic model_reset();
    for (int a = 0; a < 256; a++) mdl[a] = 8'h00;
    mdl[8'h48] = 8'h01;
    mdl[8'h90] = 8'h01;
  endtask

  task automatic model_write(input logic [5:0] dw, input logic [3:0] be, input logic [31:0] wd);
    bit pm_t = 0, smb_t = 0, d2_t = 0;
    logic [31:0] v;
    for (int l = 0; l < 4; l++) begin
      int a = int'(dw) * 4 + l;
      if (be[l] && kept_byte(a)) mdl[a] = wd[8*l +: 8];
      if (be[l] && a >= 8'h48 && a <= 8'h4B) pm_t = 1;
      if (be[l] && a >= 8'h90 && a <= 8'h93) smb_t = 1;
      if (be[l] && a == 8'hD2) d2_t = 1;
    end
    if (pm_t) begin
      v = {mdl[8'h4B], mdl[8'h4A], mdl[8'h49], mdl[8'h48]};
      v = (v & 32'h0000FF80) | 32'h1;
      {mdl[8'h4B], mdl[8'h4A], mdl[8'h49], mdl[8'h48]} = v;
    end
    if (smb_t) begin
      v = {mdl[8'h93], mdl[8'h92], mdl[8'h91], mdl[8'h90]};
      v = (v & 32'h0000FFF0) | 32'h1;
      {mdl[8'h93], mdl[8'h92], mdl[8'h91], mdl[8'h90]} = v;
    end
    if (d2_t) mdl[8'hD2] = mdl[8'hD2] & 8'h0F;
  endtask

  // drive one cycle, compare everything against the model, then commit the write
  task automatic tick(input logic wr, input logic [5:0] dw, input logic [3:0] be,
                      input logic [31:0] wd, input logic [15:0] ia, input logic single);
    logic [15:0] pmb, smbb;
    bit pm_m, smb_m, e_pm, e_smb;
    int b;
    cfg_wr = wr; cfg_dw_addr = dw; cfg_be = be; cfg_wdata = wd;
    io_addr = ia; io_single = single;
    #1;
    b = int'(dw) * 4;
    chk("R4 readback", cfg_rdata, {mdl[b+3], mdl[b+2], mdl[b+1], mdl[b]});
    pmb   = {mdl[8'h49], mdl[8'h48]} & 16'hFF80;
    smbb  = {mdl[8'h91], mdl[8'h90]} & 16'hFFF0;
    pm_m  = mdl[8'h41][7] && ((ia & 16'hFF80) == pmb);
    smb_m = mdl[8'hD2][0] && ((ia & 16'hFFF0) == smbb);
    e_pm  = pm_m && single;
    e_smb = smb_m && !pm_m;
    if (pm_m && !single) chk("R12 pm_hit", {31'b0, pm_hit}, {31'b0, e_pm});
    else                 chk("R9 pm_hit",  {31'b0, pm_hit}, {31'b0, e_pm});
    if (pm_m && smb_m)   chk("R13 smb_hit", {31'b0, smb_hit}, {31'b0, e_smb});
    else                 chk("R10 smb_hit", {31'b0, smb_hit}, {31'b0, e_smb});
    chk("R11 pm_off",  {25'b0, pm_off},  e_pm  ? {25'b0, ia[6:0]} : 32'h0);
    chk("R11 smb_off", {28'b0, smb_off}, e_smb ? {28'b0, ia[3:0]} : 32'h0);
    @(posedge clk);
    if (wr) model_write(dw, be, wd);
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic wr_cfg(input logic [5:0] dw, input logic [3:0] be, input logic [31:0] wd);
    tick(1'b1, dw, be, wd, 16'h0000, 1'b1);
  endtask

  task automatic rd_const(input logic [5:0] dw, input logic [31:0] exp, input string tag);
    cfg_wr = 1'b0; cfg_dw_addr = dw; cfg_be = 4'h0; cfg_wdata = '0;
    #1;
    chk(tag, cfg_rdata, exp);
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(4 * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog (all requirements) act=hung exp=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [5:0] rd_list [4];
    rd_list[0] = 6'h10; rd_list[1] = 6'h12; rd_list[2] = 6'h24; rd_list[3] = 6'h34;
    rst_n = 1'b0; cfg_wr = 1'b0; cfg_dw_addr = '0; cfg_be = '0; cfg_wdata = '0;
    io_addr = '0; io_single = 1'b1;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 reset values
    rd_const(6'h12, 32'h0000_0001, "R1 pm base");
    rd_const(6'h24, 32'h0000_0001, "R1 smb base");
    rd_const(6'h10, 32'h0000_0000, "R1 pm ctl");
    rd_const(6'h34, 32'h0000_0000, "R1 smb ctl");
    io_addr = 16'h0000; io_single = 1'b1; #1;
    chk("R1 no hit", {30'b0, pm_hit, smb_hit}, 32'h0);
    @(negedge clk);

    // R2 power-management base masking
    wr_cfg(6'h12, 4'hF, 32'hFFFF_FFFF);
    rd_const(6'h12, 32'h0000_FF81, "R2 all ones");
    wr_cfg(6'h12, 4'hF, 32'h0000_1234);
    rd_const(6'h12, 32'h0000_1201, "R2 value");
    // R7 byte lanes
    wr_cfg(6'h12, 4'h1, 32'h0000_00FF);
    rd_const(6'h12, 32'h0000_1281, "R7 lane0 only");
    wr_cfg(6'h12, 4'hC, 32'hFFFF_FFFF);
    rd_const(6'h12, 32'h0000_1281, "R2 upper lanes dropped");

    // R3 SMBus base masking
    wr_cfg(6'h24, 4'hF, 32'hABCD_FFFF);
    rd_const(6'h24, 32'h0000_FFF1, "R3 all ones");
    wr_cfg(6'h24, 4'hF, 32'h0000_1238);
    rd_const(6'h24, 32'h0000_1231, "R3 value");

    // R8 unused bytes
    wr_cfg(6'h11, 4'hF, 32'hDEAD_BEEF);
    rd_const(6'h11, 32'h0000_0000, "R8 dword 0x44");
    wr_cfg(6'h10, 4'hD, 32'hFFFF_FFFF);
    rd_const(6'h10, 32'h0000_0000, "R8 neighbours of 0x41");

    // R5 / R6 enables
    wr_cfg(6'h10, 4'h2, 32'h0000_8000);
    rd_const(6'h10, 32'h0000_8000, "R5 enable byte");
    wr_cfg(6'h34, 4'h4, 32'h00FF_0000);
    rd_const(6'h34, 32'h000F_0000, "R6 keep nibble");

    // sweep both separate windows, mixing access widths
    for (int a = 16'h1210; a < 16'h1310; a++)
      tick(1'b0, rd_list[a % 4], 4'h0, 32'h0, a[15:0], (a % 3) != 0);

    // R13 move SMBus window inside the power-management window
    wr_cfg(6'h24, 4'h3, 32'h0000_12A0);
    for (int a = 16'h1290; a < 16'h12C0; a++)
      tick(1'b0, rd_list[a % 4], 4'h0, 32'h0, a[15:0], (a % 4) != 1);

    // disable power-management window: SMBus takes the shared range
    wr_cfg(6'h10, 4'h2, 32'h0000_0000);
    for (int a = 16'h1290; a < 16'h12C0; a++)
      tick(1'b0, rd_list[a % 4], 4'h0, 32'h0, a[15:0], (a % 2) == 0);

    // mixed random traffic, including writes that toggle the enables
    for (int i = 0; i < 600; i++) begin
      logic [31:0] r = $urandom;
      logic [15:0] ia = 16'h1200 | 16'(r[8:0]);
      if (r[31:28] == 4'h0)
        tick(1'b1, 6'h10, 4'h2, {16'h0, r[27], 15'h0}, ia, r[9]);
      else if (r[31:28] == 4'h1)
        tick(1'b1, 6'h34, 4'h4, {8'h0, r[27:20], 16'h0}, ia, r[9]);
      else if (r[31:28] == 4'h2)
        tick(1'b1, 6'h12, 4'h3, {16'h0, 7'h09, r[24:16]}, ia, r[9]);
      else if (r[31:28] == 4'h3)
        tick(1'b1, 6'h24, 4'h3, {16'h0, 4'h1, r[27:16]}, ia, r[9]);
      else
        tick(1'b0, rd_list[i % 4], 4'h0, 32'h0, ia, r[9] | r[10]);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule